// File: doc/BRIEF.md
# Programmable Down-Counting Timer

This block is one 16-bit down counter with a byte-wide register port. Software sets an operating mode, loads a reload value in two byte writes, and then starts the counter with a trigger command. The counter steps down while its gate is open. When it passes its final count it raises a terminal-count event. That event drives an output waveform and sets an interrupt-pending flag.

The mode picks one of three waveforms: a single-clock pulse, a one-shot level, or a square wave. It also picks between stopping after one run and reloading forever. External pins can gate the count, trigger it, or supply the count clock. The mode also selects whether a trigger during a run restarts it. A hold control freezes the readable count so that software can read both bytes of one value, even though the counter keeps running.

Top module: `ctmr_top`

## Requirements
- R1: After synchronous reset every register reads 0: mode, control/status, reload bytes and count bytes. `tmr_out` and `irq` are 0.
- R2: A trigger loads the reload value into the counter and sets count-in-progress (status bit 0) on the same clock edge. A trigger is a control write (address 1) with bit 1 set, or a rising edge of `ext_trig` while mode bit 4 is set. Mode register (address 0) reads back as written. The reload value is written at address 2 (high byte) and address 3 (low byte). The count is read at address 4 (high byte) and address 5 (low byte).
- R3: While counting, the counter drops by one on every clock in which the gate is open. The gate is control bit 2, ANDed with `ext_gate` when mode bit 3 is set. While the gate is closed the count holds.
- R4: With mode bit 5 set, the counter steps only on a rising edge of `ext_cnt`.
- R5: Mode bit 7 = 0 selects single-cycle operation. The step from count 1 is the terminal count: the count becomes 0 and count-in-progress clears. A reload value of 0 counts 65536 steps.
- R6: Mode bit 7 = 1 selects continuous operation. At terminal count the counter reloads the reload value and keeps running.
- R7: Mode bits [1:0] = 00 select pulse output. The waveform is high for exactly the one clock after the terminal-count edge.
- R8: Mode bits [1:0] = 01 select one-shot output. The waveform rises on an accepted trigger and falls at terminal count.
- R9: Mode bits [1:0] = 10 select square-wave output. The waveform is cleared by a trigger that starts a run, then toggles at each terminal count.
- R10: A trigger during a run reloads the counter only if mode bit 2 is set. Otherwise the trigger is ignored and counting goes on.
- R11: Writing control bit 3 = 1 freezes the readable count at its value in that cycle. Control bit 3 reads as 1 until a strobed read of address 5 clears it. After that the readable count follows the live counter again.
- R12: Terminal count sets interrupt-pending (status bit 5). Writing the control register with bit 5 set clears interrupt-pending. `irq` is interrupt-pending ANDed with interrupt-enable (control bit 6).
- R13: `tmr_out` carries the waveform only while mode bit 6 is set. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect on address 5 only) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| ext_gate | input | 1 | External gate level |
| ext_trig | input | 1 | External trigger, rising edge |
| ext_cnt | input | 1 | External count clock, rising edge |
| tmr_out | output | 1 | Waveform output |
| irq | output | 1 | Interrupt request |

## Verification
The checker assumes the following about the inputs:
- The external pins are already synchronous to `clk`.
- Read and write strobes are never asserted in the same cycle.

The bench drives every input at the falling clock edge and issues one register access at a time. This keeps it inside both assumptions. With those inputs, a trigger always produces the reload value on the next cycle, and the readable count stays constant while the hold control is set.

// File: rtl/ctmr_pkg.sv
// Package: shared register addresses, bit positions and mode layout of the
// down-counting timer. Assumes an 8-bit register port.
package ctmr_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_MODE   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd1;
    localparam logic [ADDR_W-1:0] A_RLD_HI = 3'd2;
    localparam logic [ADDR_W-1:0] A_RLD_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd4;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd5;

    // control/status bit positions
    localparam int C_RUN  = 0;
    localparam int C_TRIG = 1;
    localparam int C_GATE = 2;
    localparam int C_HOLD = 3;
    localparam int C_PEND = 5;
    localparam int C_IEN  = 6;

    typedef enum logic [1:0] {
        FORM_PULSE   = 2'b00,
        FORM_ONESHOT = 2'b01,
        FORM_SQUARE  = 2'b10,
        FORM_RSVD    = 2'b11
    } form_e;

    // packed MSB first: bit7 continuous ... bits[1:0] waveform form
    typedef struct packed {
        logic  cont;
        logic  out_en;
        logic  xcnt_en;
        logic  xtrig_en;
        logic  xgate_en;
        logic  retrig_en;
        form_e form;
    } mode_t;

endpackage

// File: rtl/ctmr_regs.sv
// Module: register file and read multiplexer. Holds mode, reload value,
// gate command, interrupt enable and interrupt-pending; emits single-cycle
// strobes for trigger and hold control. Assumes wr and rd are never
// asserted together.
module ctmr_regs
    import ctmr_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              run,
    input  logic              tc_evt,
    input  logic              hold,
    input  logic [CNT_W-1:0]  view_cnt,
    output mode_t             mode,
    output logic [CNT_W-1:0]  rld,
    output logic              gate_cmd,
    output logic              sw_trig,
    output logic              hold_wr,
    output logic              hold_val,
    output logic              lsb_rd,
    output logic              pend,
    output logic              ien
);

    logic wr_ctrl;

    assign wr_ctrl  = wr && (addr == A_CTRL);
    assign sw_trig  = wr_ctrl && wdata[C_TRIG];
    assign hold_wr  = wr_ctrl;
    assign hold_val = wdata[C_HOLD];
    assign lsb_rd   = rd && (addr == A_CNT_LO);

    // configuration registers written from the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= '0;
            rld      <= '0;
            gate_cmd <= 1'b0;
            ien      <= 1'b0;
        end else if (wr) begin
            case (addr)
                A_MODE:   mode <= mode_t'(wdata);
                A_RLD_HI: rld[CNT_W-1:DATA_W] <= wdata;
                A_RLD_LO: rld[DATA_W-1:0] <= wdata;
                A_CTRL: begin
                    gate_cmd <= wdata[C_GATE];
                    ien      <= wdata[C_IEN];
                end
                default: ;
            endcase
        end
    end

    // interrupt-pending: set by terminal count, cleared by write-one
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (tc_evt)
            pend <= 1'b1;
        else if (wr_ctrl && wdata[C_PEND])
            pend <= 1'b0;
    end

    // combinational read multiplexer
    always_comb begin
        rdata = '0;
        case (addr)
            A_MODE:   rdata = DATA_W'(mode);
            A_CTRL: begin
                rdata[C_RUN]  = run;
                rdata[C_GATE] = gate_cmd;
                rdata[C_HOLD] = hold;
                rdata[C_PEND] = pend;
                rdata[C_IEN]  = ien;
            end
            A_RLD_HI: rdata = rld[CNT_W-1:DATA_W];
            A_RLD_LO: rdata = rld[DATA_W-1:0];
            A_CNT_HI: rdata = view_cnt[CNT_W-1:DATA_W];
            A_CNT_LO: rdata = view_cnt[DATA_W-1:0];
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/ctmr_rdhold.sv
// Module: read-hold snapshot. While hold is clear the snapshot tracks the
// live count; setting hold freezes it until the low byte is read.
// Assumes lsb_rd and hold_wr do not occur in the same cycle.
module ctmr_rdhold #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_wr,
    input  logic             hold_val,
    input  logic             lsb_rd,
    input  logic [CNT_W-1:0] live_cnt,
    output logic             hold,
    output logic [CNT_W-1:0] view_cnt
);

    logic [CNT_W-1:0] snap;

    // snapshot tracking and hold flag update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap <= '0;
            hold <= 1'b0;
        end else begin
            if (!hold)
                snap <= live_cnt;
            if (lsb_rd)
                hold <= 1'b0;
            else if (hold_wr)
                hold <= hold_val;
        end
    end

    assign view_cnt = hold ? snap : live_cnt;

endmodule

// File: rtl/ctmr_core.sv
// Module: counting engine. Detects external edges, forms gate and tick,
// accepts triggers, decrements and reloads, and flags terminal count.
// Assumes ext_* inputs are already synchronous to clk.
module ctmr_core
    import ctmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_t            mode,
    input  logic [CNT_W-1:0] rld,
    input  logic             gate_cmd,
    input  logic             sw_trig,
    input  logic             ext_gate,
    input  logic             ext_trig,
    input  logic             ext_cnt,
    output logic [CNT_W-1:0] cnt,
    output logic             run,
    output logic             tc_evt,
    output logic             trig_acc
);

    localparam int N_EDGE = 2;

    logic [N_EDGE-1:0] ext_in;
    logic [N_EDGE-1:0] ext_prev;
    logic [N_EDGE-1:0] ext_rise;
    logic              trig_req;
    logic              gate_on;
    logic              tick;
    logic              step;

    assign ext_in = {ext_cnt, ext_trig};

    for (genvar gi = 0; gi < N_EDGE; gi++) begin : g_edge
        // previous-value register for rising-edge detection
        always_ff @(posedge clk) begin
            if (!rst_n)
                ext_prev[gi] <= 1'b0;
            else
                ext_prev[gi] <= ext_in[gi];
        end
        assign ext_rise[gi] = ext_in[gi] && !ext_prev[gi];
    end

    assign trig_req = sw_trig || (mode.xtrig_en && ext_rise[0]);
    assign trig_acc = trig_req && (!run || mode.retrig_en);
    assign gate_on  = gate_cmd && (!mode.xgate_en || ext_gate);
    assign tick     = mode.xcnt_en ? ext_rise[1] : 1'b1;
    assign step     = run && gate_on && tick && !trig_acc;
    assign tc_evt   = step && (cnt == CNT_W'(1));

    // counter and run flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (trig_acc) begin
            cnt <= rld;
            run <= 1'b1;
        end else if (tc_evt) begin
            if (mode.cont) begin
                cnt <= rld;
            end else begin
                cnt <= '0;
                run <= 1'b0;
            end
        end else if (step) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

endmodule

// File: rtl/ctmr_wave.sv
// Module: output waveform generator for pulse, one-shot and square forms.
// Assumes trig_acc and tc_evt are mutually exclusive.
module ctmr_wave
    import ctmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  form_e form,
    input  logic  out_en,
    input  logic  run,
    input  logic  trig_acc,
    input  logic  tc_evt,
    output logic  wave,
    output logic  pin_out
);

    // waveform state per selected form
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave <= 1'b0;
        end else begin
            case (form)
                FORM_ONESHOT: begin
                    if (tc_evt)
                        wave <= 1'b0;
                    else if (trig_acc)
                        wave <= 1'b1;
                end
                FORM_SQUARE: begin
                    if (trig_acc && !run)
                        wave <= 1'b0;
                    else if (tc_evt)
                        wave <= !wave;
                end
                default: wave <= tc_evt;
            endcase
        end
    end

    assign pin_out = out_en && wave;

endmodule

// File: rtl/ctmr_top.sv
// Module: top of the programmable down-counting timer. Wires the register
// file, counting engine, read-hold snapshot and waveform generator.
// Assumes a single clock domain and synchronous external pins.
module ctmr_top
    import ctmr_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_gate,
    input  logic              ext_trig,
    input  logic              ext_cnt,
    output logic              tmr_out,
    output logic              irq
);

    mode_t            mode;
    logic [CNT_W-1:0] rld;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] view_cnt;
    logic             gate_cmd;
    logic             sw_trig;
    logic             hold_wr;
    logic             hold_val;
    logic             lsb_rd;
    logic             hold;
    logic             pend;
    logic             ien;
    logic             run;
    logic             tc_evt;
    logic             trig_acc;
    logic             wave;

    ctmr_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .run      (run),
        .tc_evt   (tc_evt),
        .hold     (hold),
        .view_cnt (view_cnt),
        .mode     (mode),
        .rld      (rld),
        .gate_cmd (gate_cmd),
        .sw_trig  (sw_trig),
        .hold_wr  (hold_wr),
        .hold_val (hold_val),
        .lsb_rd   (lsb_rd),
        .pend     (pend),
        .ien      (ien)
    );

    ctmr_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .rld      (rld),
        .gate_cmd (gate_cmd),
        .sw_trig  (sw_trig),
        .ext_gate (ext_gate),
        .ext_trig (ext_trig),
        .ext_cnt  (ext_cnt),
        .cnt      (cnt),
        .run      (run),
        .tc_evt   (tc_evt),
        .trig_acc (trig_acc)
    );

    ctmr_rdhold #(.CNT_W(CNT_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_wr  (hold_wr),
        .hold_val (hold_val),
        .lsb_rd   (lsb_rd),
        .live_cnt (cnt),
        .hold     (hold),
        .view_cnt (view_cnt)
    );

    ctmr_wave u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .form     (mode.form),
        .out_en   (mode.out_en),
        .run      (run),
        .trig_acc (trig_acc),
        .tc_evt   (tc_evt),
        .wave     (wave),
        .pin_out  (tmr_out)
    );

    assign irq = pend && ien;

endmodule

// File: rtl/ctmr_checker.sv
// Module: property checker for the timer, bound into ctmr_top.
// Assumes synchronous external inputs and no simultaneous rd/wr.
module ctmr_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cont,
    input logic             run,
    input logic             trig_acc,
    input logic             tc_evt,
    input logic             pend,
    input logic             hold,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] rld,
    input logic [CNT_W-1:0] view_cnt
);

    assert_trig_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trig_acc |=> (run && cnt == $past(rld)));

    assert_idle_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !trig_acc) |=> $stable(cnt));

    assert_single_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_evt && !cont) |=> (!run && cnt == '0));

    assert_run_ends_at_tc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> $past(tc_evt));

    assert_cont_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_evt && cont) |=> (run && cnt == $past(rld)));

    assert_hold_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && $past(hold)) |-> $stable(view_cnt));

    assert_pend_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
        tc_evt |=> pend);

endmodule

bind ctmr_top ctmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cont     (mode.cont),
    .run      (run),
    .trig_acc (trig_acc),
    .tc_evt   (tc_evt),
    .pend     (pend),
    .hold     (hold),
    .cnt      (cnt),
    .rld      (rld),
    .view_cnt (view_cnt)
);

// File: tb/ctmr_top_tb.sv
module ctmr_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ext_gate = 1'b0;
    logic       ext_trig = 1'b0;
    logic       ext_cnt = 1'b0;
    logic       tmr_out;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = !clk;

    ctmr_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ext_gate  (ext_gate),
        .ext_trig  (ext_trig),
        .ext_cnt   (ext_cnt),
        .tmr_out   (tmr_out),
        .irq       (irq)
    );

    // {mode, reload, cycles after trigger, expected count, 7'b0, expected run}
    localparam int NV = 8;
    localparam logic [63:0] VEC [NV] = '{
        {8'h00, 16'd10,  16'd3,   16'd7,   8'h01},
        {8'h00, 16'd10,  16'd10,  16'd0,   8'h00},
        {8'h00, 16'd5,   16'd20,  16'd0,   8'h00},
        {8'h80, 16'd4,   16'd6,   16'd2,   8'h01},
        {8'h80, 16'd4,   16'd8,   16'd4,   8'h01},
        {8'h80, 16'd300, 16'd1,   16'd299, 8'h01},
        {8'h00, 16'h100, 16'd255, 16'd1,   8'h01},
        {8'h02, 16'd3,   16'd2,   16'd1,   8'h01}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ext_gate = 1'b0;
        ext_trig = 1'b0;
        ext_cnt = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd_cnt(output int c);
        logic [7:0] h;
        logic [7:0] l;
        rd(3'd4, h);
        rd(3'd5, l);
        c = {h, l};
    endtask

    task automatic setup(input logic [7:0] m, input logic [15:0] r);
        wr(3'd0, m);
        wr(3'd2, r[15:8]);
        wr(3'd3, r[7:0]);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int c;
        logic [7:0] b;
        @(negedge clk);
        do_reset();

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), b);
            chk("R1 reg", b, 0);
        end
        chk("R1 tmr_out", tmr_out, 0);
        chk("R1 irq", irq, 0);

        // vector table: R2 R5 R6
        for (int i = 0; i < NV; i++) begin
            do_reset();
            setup(VEC[i][63:56], VEC[i][55:40]);
            rd(3'd0, b);
            chk("R2 mode readback", b, VEC[i][63:56]);
            wr(3'd1, 8'h06);
            repeat (VEC[i][39:24]) @(negedge clk);
            rd_cnt(c);
            chk("R5/R6 count", c, VEC[i][23:8]);
            rd(3'd1, b);
            chk("R2/R5 run flag", b[0], VEC[i][0]);
        end

        // R3 software gate closed then opened
        do_reset();
        setup(8'h00, 16'd20);
        wr(3'd1, 8'h02);
        repeat (5) @(negedge clk);
        rd_cnt(c);
        chk("R3 gate closed hold", c, 20);
        wr(3'd1, 8'h04);
        repeat (3) @(negedge clk);
        rd_cnt(c);
        chk("R3 gate open", c, 17);

        // R3 external gate
        do_reset();
        setup(8'h08, 16'd6);
        wr(3'd1, 8'h06);
        repeat (3) @(negedge clk);
        rd_cnt(c);
        chk("R3 ext gate low", c, 6);
        ext_gate = 1'b1;
        repeat (2) @(negedge clk);
        rd_cnt(c);
        chk("R3 ext gate high", c, 4);

        // R4 external count edges
        do_reset();
        setup(8'h20, 16'd5);
        wr(3'd1, 8'h06);
        repeat (4) @(negedge clk);
        rd_cnt(c);
        chk("R4 no edges", c, 5);
        for (int k = 0; k < 2; k++) begin
            ext_cnt = 1'b1;
            @(negedge clk);
            ext_cnt = 1'b0;
            @(negedge clk);
        end
        rd_cnt(c);
        chk("R4 two edges", c, 3);

        // R7 pulse output, R12 interrupt, R13 pin enable
        do_reset();
        setup(8'h40, 16'd3);
        wr(3'd1, 8'h46);
        repeat (2) @(negedge clk);
        chk("R7 before tc", tmr_out, 0);
        @(negedge clk);
        chk("R7 pulse high", tmr_out, 1);
        chk("R12 irq set", irq, 1);
        rd(3'd1, b);
        chk("R12 pending bit", b[5], 1);
        @(negedge clk);
        chk("R7 pulse one clock", tmr_out, 0);
        wr(3'd1, 8'h60);
        chk("R12 irq cleared", irq, 0);

        // R8 one-shot
        do_reset();
        setup(8'h41, 16'd4);
        wr(3'd1, 8'h06);
        chk("R8 rise at trigger", tmr_out, 1);
        repeat (3) @(negedge clk);
        chk("R8 high during run", tmr_out, 1);
        @(negedge clk);
        chk("R8 fall at tc", tmr_out, 0);
        chk("R12 no irq when disabled", irq, 0);

        // R9 square wave, continuous
        do_reset();
        setup(8'hC2, 16'd2);
        wr(3'd1, 8'h06);
        chk("R9 start low", tmr_out, 0);
        repeat (2) @(negedge clk);
        chk("R9 first toggle", tmr_out, 1);
        repeat (2) @(negedge clk);
        chk("R9 second toggle", tmr_out, 0);

        // R13 pin disabled
        do_reset();
        setup(8'h01, 16'd4);
        wr(3'd1, 8'h06);
        @(negedge clk);
        chk("R13 pin off", tmr_out, 0);

        // R10 retrigger ignored, then accepted
        do_reset();
        setup(8'h00, 16'd10);
        wr(3'd1, 8'h06);
        repeat (4) @(negedge clk);
        wr(3'd1, 8'h06);
        rd_cnt(c);
        chk("R10 trigger ignored", c, 5);
        wr(3'd0, 8'h04);
        wr(3'd1, 8'h06);
        rd_cnt(c);
        chk("R10 retrigger reloads", c, 10);

        // R2 external trigger
        do_reset();
        setup(8'h10, 16'd7);
        wr(3'd1, 8'h04);
        rd(3'd1, b);
        chk("R2 idle before ext trig", b[0], 0);
        ext_trig = 1'b1;
        @(negedge clk);
        ext_trig = 1'b0;
        rd_cnt(c);
        chk("R2 ext trig loads", c, 7);

        // R11 read hold
        do_reset();
        setup(8'h00, 16'h0200);
        wr(3'd1, 8'h06);
        repeat (5) @(negedge clk);
        wr(3'd1, 8'h0C);
        repeat (10) @(negedge clk);
        rd(3'd1, b);
        chk("R11 hold bit", b[3], 1);
        rd(3'd4, b);
        chk("R11 held msb", b, 8'h01);
        bus_rd = 1'b1;
        rd(3'd5, b);
        chk("R11 held lsb", b, 8'hFB);
        @(negedge clk);
        bus_rd = 1'b0;
        rd_cnt(c);
        chk("R11 live after release", c, 16'h01EF);
        rd(3'd1, b);
        chk("R11 hold cleared", b[3], 0);

        // R5 reload 0 means 65536 steps
        do_reset();
        setup(8'h00, 16'd0);
        wr(3'd1, 8'h06);
        repeat (65535) @(negedge clk);
        rd_cnt(c);
        chk("R5 zero reload near end", c, 1);
        @(negedge clk);
        rd(3'd1, b);
        chk("R5 zero reload done", b[0], 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule